// File: doc/BRIEF.md
# NAND Correction Engine Control Register Block

This block is the register front end of a NAND error-correction processing engine. Software reaches it over a plain 32-bit register bus: a byte address, a write strobe, write data and combinational read data. Through it, software enables the engine, picks a correction-strength index and shapes the host transfer with layout and burst bits. It sets how many chunks one command covers, then fires a transfer with a start bit and a direction bit. When the transfer finishes, the completion shows up in an interrupt status register.

Every interrupt source passes two masks. The status-enable mask decides whether an event is latched into the status register at all. The signal-enable mask decides whether a latched bit drives the interrupt output. Software clears a status bit by writing a one to it. A small stand-in datapath takes the start command and reports completion after a fixed per-chunk latency times the chunk count. The correction arithmetic and the DMA movers are not modelled. Three sources (correction error and the two direction-change flags) come from a hardware event input fed by neighbouring logic.

Top module: `ecc_ctrl_top`

## Requirements
- R1: After reset, every writable register reads 0 and `irqOut` is low.
- R2: Offset 0x00 holds the engine enable in bit 0 and the correction-type index in bits 6:3. All other bits read 0.
- R3: Offset 0x04 is the status register, with sources bit 0 transfer complete, bit 1 main-area move done, bit 2 spare-area move done, bit 3 correction error, bit 4 switch-to-spare and bit 5 switch-to-main. An event sets its bit only when the same bit of the status-enable mask at 0x08 is 1.
- R4: Writing 1 to a bit of 0x04 clears that bit. Writing 0 leaves it unchanged.
- R5: `irqOut` is high exactly when some status bit is set and the same bit of the signal-enable mask at 0x0C is 1.
- R6: When a hardware event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: Offset 0x40 holds start in bit 31, read-from-NAND in bit 1 (0 means write), continue-NAND in bit 29 and continue-system-memory in bit 30. A start written while the engine enable is 0 is dropped, but the other bits are still stored. An accepted start reads back as 1 until the datapath takes it on the next clock, and then reads back as 0.
- R8: Status bits 0, 1 and 2 are set together at the clock edge N*DONE_LAT+1 cycles after the edge that wrote start. N is the chunk count at 0x30, and a count of 0 counts as 1.
- R9: Offset 0x10 keeps bit 0 (incrementing burst), bit 2 (interleaved layout), bit 4 (memory-to-memory) and bit 5 (mapping mode). All other bits read 0.
- R10: Offset 0xD0 reads the VERSION parameter in bits 31:16 and zero elsewhere. Writes to it have no effect.
- R11: Any address outside the mapped offsets reads 0.
- R12: The `hwEvent` input sets status bits 3 to 5 in the cycle it is high, subject to the status-enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| hwEvent | input | 6 | Single-cycle hardware event pulses, one per status source |
| irqOut | output | 1 | Interrupt line |

## Verification
The bench builds the block with DONE_LAT set to 4, an 8-bit chunk count and a version of 0x00A5. With these values, transfers of one, three and zero chunks each finish within a few dozen cycles. Each completion edge can be checked to the exact cycle, both one cycle before and at the edge. Short latencies also make it cheap to steer an event pulse onto the same edge as a clearing write. The bench also checks that a start written while the engine is disabled leaves the status register at 0.

// File: rtl/ecc_ctrl_pkg.sv
package ecc_ctrl_pkg;
  localparam int NSRC   = 6;
  localparam int TYPE_W = 4;
  localparam int TYPE_LSB = 3;

  localparam int OFF_CFG   = 'h00;
  localparam int OFF_STS   = 'h04;
  localparam int OFF_STEN  = 'h08;
  localparam int OFF_SGEN  = 'h0C;
  localparam int OFF_HOST  = 'h10;
  localparam int OFF_CHUNK = 'h30;
  localparam int OFF_XFER  = 'h40;
  localparam int OFF_VER   = 'hD0;

  localparam int SRC_XFER  = 0;
  localparam int SRC_MAIN  = 1;
  localparam int SRC_SPARE = 2;

  typedef struct packed {
    logic start;
    logic readDir;
  } cmd_t;

  typedef struct packed {
    logic accept;
    logic busy;
    logic done;
  } rsp_t;
endpackage

// File: rtl/ecc_ctrl_regfile.sv
module ecc_ctrl_regfile
  import ecc_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CHUNK_W = 8,
  parameter logic [15:0] VERSION = 16'h0003
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NSRC-1:0]    evtIn,
  input  rsp_t               rsp,
  output cmd_t               cmd,
  output logic [CHUNK_W-1:0] chunkCnt,
  output logic [NSRC-1:0]    statusQ,
  output logic [NSRC-1:0]    staEnQ,
  output logic [NSRC-1:0]    sigEnQ,
  output logic               engEnQ,
  output logic               startPendQ,
  output logic               irqOut
);
  logic [TYPE_W-1:0] corrType;
  logic hcBurst, hcIlv, hcM2m, hcMap;
  logic readDir, contNand, contSys;
  logic [NSRC-1:0] clrMask;

  logic hitCfg, hitSts, hitStEn, hitSgEn, hitHost, hitChunk, hitXfer, hitVer;
  assign hitCfg   = busAddr == ADDR_W'(OFF_CFG);
  assign hitSts   = busAddr == ADDR_W'(OFF_STS);
  assign hitStEn  = busAddr == ADDR_W'(OFF_STEN);
  assign hitSgEn  = busAddr == ADDR_W'(OFF_SGEN);
  assign hitHost  = busAddr == ADDR_W'(OFF_HOST);
  assign hitChunk = busAddr == ADDR_W'(OFF_CHUNK);
  assign hitXfer  = busAddr == ADDR_W'(OFF_XFER);
  assign hitVer   = busAddr == ADDR_W'(OFF_VER);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engEnQ   <= 1'b0;
      corrType <= '0;
      staEnQ   <= '0;
      sigEnQ   <= '0;
      hcBurst  <= 1'b0;
      hcIlv    <= 1'b0;
      hcM2m    <= 1'b0;
      hcMap    <= 1'b0;
      chunkCnt <= '0;
      readDir  <= 1'b0;
      contNand <= 1'b0;
      contSys  <= 1'b0;
    end else if (busWe) begin
      if (hitCfg) begin
        engEnQ   <= busWdata[0];
        corrType <= busWdata[TYPE_LSB +: TYPE_W];
      end
      if (hitStEn) staEnQ <= busWdata[NSRC-1:0];
      if (hitSgEn) sigEnQ <= busWdata[NSRC-1:0];
      if (hitHost) begin
        hcBurst <= busWdata[0];
        hcIlv   <= busWdata[2];
        hcM2m   <= busWdata[4];
        hcMap   <= busWdata[5];
      end
      if (hitChunk) chunkCnt <= busWdata[CHUNK_W-1:0];
      if (hitXfer) begin
        readDir  <= busWdata[1];
        contNand <= busWdata[29];
        contSys  <= busWdata[30];
      end
    end
  end

  // start bit: set by an enabled write, dropped when the datapath takes it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPendQ <= 1'b0;
    end else if (busWe && hitXfer && busWdata[31] && engEnQ) begin
      startPendQ <= 1'b1;
    end else if (rsp.accept) begin
      startPendQ <= 1'b0;
    end
  end

  assign clrMask = (busWe && hitSts) ? busWdata[NSRC-1:0] : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[i] <= 1'b0;
      end else if (evtIn[i] && staEnQ[i]) begin
        statusQ[i] <= 1'b1;
      end else if (clrMask[i]) begin
        statusQ[i] <= 1'b0;
      end
    end
  end

  assign irqOut = |(statusQ & sigEnQ);

  assign cmd.start   = startPendQ;
  assign cmd.readDir = readDir;

  always_comb begin
    busRdata = '0;
    unique case (1'b1)
      hitCfg: begin
        busRdata[0] = engEnQ;
        busRdata[TYPE_LSB +: TYPE_W] = corrType;
      end
      hitSts:  busRdata[NSRC-1:0] = statusQ;
      hitStEn: busRdata[NSRC-1:0] = staEnQ;
      hitSgEn: busRdata[NSRC-1:0] = sigEnQ;
      hitHost: begin
        busRdata[0] = hcBurst;
        busRdata[2] = hcIlv;
        busRdata[4] = hcM2m;
        busRdata[5] = hcMap;
      end
      hitChunk: busRdata[CHUNK_W-1:0] = chunkCnt;
      hitXfer: begin
        busRdata[31] = startPendQ;
        busRdata[30] = contSys;
        busRdata[29] = contNand;
        busRdata[1]  = readDir;
      end
      hitVer:  busRdata[31:16] = VERSION;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_ctrl_stub.sv
module ecc_ctrl_stub
  import ecc_ctrl_pkg::*;
#(
  parameter int DONE_LAT = 4,
  parameter int CHUNK_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmd_t               cmd,
  input  logic [CHUNK_W-1:0] chunkCnt,
  output rsp_t               rsp,
  output logic [NSRC-1:0]    evtOut
);
  localparam int CYC_W = (DONE_LAT > 1) ? $clog2(DONE_LAT) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(DONE_LAT - 1);

  logic               busy;
  logic [CYC_W-1:0]   cyc;
  logic [CHUNK_W-1:0] idx, lastIdx;
  logic               accept, chunkEnd, done;

  assign accept   = cmd.start && !busy;
  assign chunkEnd = busy && (cyc == CYC_LAST);
  assign done     = chunkEnd && (idx == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cyc     <= '0;
      idx     <= '0;
      lastIdx <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cyc     <= '0;
      idx     <= '0;
      lastIdx <= (chunkCnt == '0) ? '0 : chunkCnt - 1'b1;
    end else if (busy) begin
      if (chunkEnd) begin
        cyc <= '0;
        if (done) busy <= 1'b0;
        else      idx  <= idx + 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  assign rsp.accept = accept;
  assign rsp.busy   = busy;
  assign rsp.done   = done;

  always_comb begin
    evtOut = '0;
    evtOut[SRC_XFER]  = done;
    evtOut[SRC_MAIN]  = done;
    evtOut[SRC_SPARE] = done;
  end
endmodule

// File: rtl/ecc_ctrl_top.sv
module ecc_ctrl_top
  import ecc_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CHUNK_W  = 8,
  parameter int DONE_LAT = 4,
  parameter logic [15:0] VERSION = 16'h0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [5:0]        hwEvent,
  output logic              irqOut
);
  cmd_t cmd;
  rsp_t rsp;
  logic [CHUNK_W-1:0] chunkCnt;
  logic [NSRC-1:0] stubEvt, allEvt, statusQ, staEnQ, sigEnQ;
  logic engEnQ, startPendQ;

  assign allEvt = hwEvent | stubEvt;

  ecc_ctrl_regfile #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .evtIn(allEvt), .rsp(rsp), .cmd(cmd), .chunkCnt(chunkCnt),
    .statusQ(statusQ), .staEnQ(staEnQ), .sigEnQ(sigEnQ), .engEnQ(engEnQ),
    .startPendQ(startPendQ), .irqOut(irqOut)
  );

  ecc_ctrl_stub #(.DONE_LAT(DONE_LAT), .CHUNK_W(CHUNK_W)) u_stub (
    .clk(clk), .rstN(rstN), .cmd(cmd), .chunkCnt(chunkCnt), .rsp(rsp), .evtOut(stubEvt)
  );
endmodule

// File: rtl/ecc_ctrl_chk.sv
module ecc_ctrl_chk
  import ecc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [NSRC-1:0]   allEvt,
  input logic [NSRC-1:0]   statusQ,
  input logic [NSRC-1:0]   staEnQ,
  input logic [NSRC-1:0]   sigEnQ,
  input logic              engEnQ,
  input logic              startPendQ,
  input logic              busy,
  input logic              irqOut
);
  // R4: a clearing write with no event leaves the written-one bits at 0
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_STS) && allEvt == '0)
      |=> (statusQ & $past(busWdata[NSRC-1:0])) == '0);

  // R6: an enabled event always leaves its bit set
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((allEvt & staEnQ) != '0)
      |=> (statusQ & $past(allEvt & staEnQ)) == $past(allEvt & staEnQ));

  // R3: no bit rises while its status-enable was 0
  a_r3_gated_set: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (statusQ & ~$past(statusQ) & ~$past(staEnQ)) == '0);

  // R5: no interrupt without a signal-enabled source
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (sigEnQ == '0) |-> !irqOut);

  // R7: start dropped when the engine is disabled
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_XFER) && busWdata[31] && !engEnQ && !startPendQ)
      |=> !startPendQ);

  // R7: a pending start is taken by an idle datapath on the next edge
  a_r7_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    (startPendQ && !busy && !busWe) |=> (busy && !startPendQ));
endmodule

bind ecc_ctrl_top ecc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .allEvt(allEvt), .statusQ(statusQ), .staEnQ(staEnQ), .sigEnQ(sigEnQ),
  .engEnQ(engEnQ), .startPendQ(startPendQ), .busy(rsp.busy), .irqOut(irqOut)
);

// File: tb/ecc_ctrl_top_tb.sv
module ecc_ctrl_top_tb;
  localparam int ADDR_W = 8;
  localparam int LAT = 4;
  localparam logic [15:0] VER = 16'h00A5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [5:0] hwEvent = '0;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended = 1'b0;

  ecc_ctrl_top #(.ADDR_W(ADDR_W), .CHUNK_W(8), .DONE_LAT(LAT), .VERSION(VER)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .hwEvent(hwEvent), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 50000 && !ended) begin
      ended = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d expected below 50000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrEv(input logic [7:0] a, input logic [31:0] d, input logic [5:0] ev);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; hwEvent = ev;
    @(negedge clk);
    busWe = 1'b0; hwEvent = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEv(a, d, 6'h00);
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    hwEvent = ev;
    @(negedge clk);
    hwEvent = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 cfg", d, 0);
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h08, d); chk("R1 staEn", d, 0);
    rd(8'h0C, d); chk("R1 sigEn", d, 0);
    rd(8'h10, d); chk("R1 host", d, 0);
    rd(8'h30, d); chk("R1 chunk", d, 0);
    rd(8'h40, d); chk("R1 xfer", d, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);
    rd(8'hD0, d); chk("R10 version", d, {VER, 16'h0});
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 cfg all ones", d, 32'h79);
    wr(8'h00, 32'h0000_0028); rd(8'h00, d); chk("R2 cfg type only", d, 32'h28);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R9 host all ones", d, 32'h35);
    wr(8'h10, 32'h0000_0014); rd(8'h10, d); chk("R9 host pattern", d, 32'h14);
    wr(8'hD0, 32'hFFFF_FFFF); rd(8'hD0, d); chk("R10 version write ignored", d, {VER, 16'h0});
    wr(8'h14, 32'h1234_5678); rd(8'h14, d); chk("R11 unmapped 0x14", d, 0);
    rd(8'h3C, d); chk("R11 unmapped 0x3C", d, 0);
    rd(8'hFC, d); chk("R11 unmapped 0xFC", d, 0);
  endtask

  task automatic t_startDisabled();
    logic [31:0] d;
    wr(8'h08, 32'h3F);
    wr(8'h40, 32'hE000_0002);
    rd(8'h40, d); chk("R7 start dropped, rest kept", d, 32'h6000_0002);
    waitCyc(20);
    rd(8'h04, d); chk("R7 no completion when disabled", d, 0);
  endtask

  task automatic t_xfer(input int n, input logic [7:0] cnt);
    logic [31:0] d;
    wr(8'h00, 32'h1);
    wr(8'h30, {24'h0, cnt});
    wr(8'h40, 32'h8000_0002);
    rd(8'h40, d); chk("R7 start pending", d[31], 1);
    waitCyc(1);
    rd(8'h40, d); chk("R7 start self-cleared", d, 32'h2);
    waitCyc(n * LAT - 1);
    rd(8'h04, d); chk($sformatf("R8 not yet done n=%0d", n), d, 0);
    waitCyc(1);
    rd(8'h04, d); chk($sformatf("R8 done n=%0d", n), d, 32'h07);
    wr(8'h04, 32'h02); rd(8'h04, d); chk("R4 partial clear", d, 32'h05);
    wr(8'h04, 32'h3F); rd(8'h04, d); chk("R4 full clear", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h08, 32'h00);
    wr(8'h30, 32'h1);
    wr(8'h40, 32'h8000_0000);
    waitCyc(LAT + 4);
    rd(8'h04, d); chk("R3 masked completion not latched", d, 0);
    pulse(6'h38);
    rd(8'h04, d); chk("R3 masked events not latched", d, 0);
    wr(8'h08, 32'h3F);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h0C, 32'h00);
    pulse(6'h08);
    rd(8'h04, d); chk("R12 event bit3 latched", d, 32'h08);
    chk("R5 irq off, no signal enable", {31'b0, irqOut}, 0);
    wr(8'h0C, 32'h10); #1;
    chk("R5 irq off, other source enabled", {31'b0, irqOut}, 0);
    wr(8'h0C, 32'h08); #1;
    chk("R5 irq on", {31'b0, irqOut}, 1);
    wr(8'h04, 32'h08); #1;
    chk("R5 irq drops after clear", {31'b0, irqOut}, 0);
    pulse(6'h30);
    rd(8'h04, d); chk("R12 events bit4 bit5", d, 32'h30);
    wr(8'h04, 32'h30);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(6'h10);
    wrEv(8'h04, 32'h3F, 6'h10);
    rd(8'h04, d); chk("R6 event beats clear", d, 32'h10);
    wrEv(8'h04, 32'h10, 6'h20);
    rd(8'h04, d); chk("R6 clear plus other event", d, 32'h20);
    wr(8'h04, 32'h3F);
    rd(8'h04, d); chk("R4 clear after collision", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_startDisabled();
    t_xfer(1, 8'd1);
    t_xfer(3, 8'd3);
    t_xfer(1, 8'd0);
    t_mask();
    t_irq();
    t_collide();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule